// File: doc/BRIEF.md
# Packed 52-bit Multiply-Accumulate Unit

This block is a vector integer datapath built from independent 64-bit lanes. In every lane it takes the low 52 bits of two multiplicand operands and forms their full unsigned 104-bit product. It then adds one half of that product, zero-extended to 64 bits, to a 64-bit accumulator operand. A single select input chooses which half is added for the whole vector: the upper half (product bits 103 down to 52) or the lower half (product bits 51 down to 0).

The vector ports are always sized for the largest configuration. The `LANES` parameter sets how many lanes are active: 2 for a 128-bit vector, or 4 for a 256-bit vector. Inputs above the active width are ignored, and outputs above it read as zero. Operands enter through a valid/ready handshake. The request then passes through a three-stage pipeline and leaves as a result vector through a second valid/ready handshake. When the consumer stalls, the whole pipeline freezes and the result is held.

Top module: `pmac52_unit`

## Requirements
- R1: In every lane, bits [63:52] of `in_mula` and `in_mulb` have no effect on the result. Only bits [51:0] take part in the multiply.
- R2: The two 52-bit multiplicands are unsigned, and the product is the exact 104-bit value. For example, (2^52-1)^2 gives an upper half of 2^52-2 and a lower half of 1.
- R3: When `in_hi` = 1, the lane result is the accumulator lane plus product bits [103:52], zero-extended to 64 bits.
- R4: When `in_hi` = 0, the lane result is the accumulator lane plus product bits [51:0], zero-extended to 64 bits.
- R5: All 64 bits of the accumulator lane take part in the addition. None of its bits are dropped.
- R6: The lane addition wraps modulo 2^64. A carry out of one lane never reaches the next lane.
- R7: Lane j occupies bits [64j+63:64j] of every vector port. Only lanes 0 to `LANES`-1 are computed. Input lanes at or above `LANES` are ignored, and `out_data` bits at or above 64*`LANES` are zero.
- R8: With `out_ready` held high and the pipeline empty, a request accepted at a rising edge shows `out_valid` = 1 after the third rising edge, counting the accepting edge. It shows `out_valid` = 0 after the first two.
- R9: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0, and on the next cycle `out_valid` stays 1 with `out_data` unchanged. Results leave in the order in which requests were accepted.
- R10: A synchronous active-high `rst` empties the pipeline. After the reset edge, `out_valid` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit accepts a request this cycle |
| in_hi | input | 1 | 1: add upper product half, 0: add lower half |
| in_acc | input | 64*MAX_LANES | Accumulator operand lanes |
| in_mula | input | 64*MAX_LANES | First multiplicand lanes (bits [51:0] used) |
| in_mulb | input | 64*MAX_LANES | Second multiplicand lanes (bits [51:0] used) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 64*MAX_LANES | Result lanes, zero above the active width |

## Verification
The bench drives garbage into multiplicand bits [63:52] and into the inactive upper lanes. A unit that leaked those bits would give wrong products, and a unit that computed the upper lanes would give non-zero upper result bits in the two-lane instance. Directed all-ones operands and accumulators catch several faults:
- a product truncated to 64 bits, which would break the upper half;
- the wrong product half selected for a mode;
- an accumulator clipped to 52 bits;
- a carry that crosses into the neighbouring lane.

Random backpressure exposes a pipeline that drops, duplicates or reorders results, or lets the output change under a stall. A directed single request checks the exact three-cycle latency, and a reset taken while the pipeline is full checks that no stale result appears.

// File: rtl/pmac52_pkg.sv
package pmac52_pkg;
   localparam int LANE_W = 64;
   localparam int MUL_W  = 52;
   localparam int PROD_W = 2 * MUL_W;

   typedef enum logic {
      HALF_LO = 1'b0,
      HALF_HI = 1'b1
   } half_sel_t;
endpackage

// File: rtl/pmac52_flow.sv
module pmac52_flow (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   input  logic out_ready,
   output logic in_ready,
   output logic advance,
   output logic out_valid
);
   logic stg1_v, stg2_v, stg3_v;

   // The whole pipeline moves only when the last stage can be emptied
   assign advance   = !stg3_v || out_ready;
   assign in_ready  = advance;
   assign out_valid = stg3_v;

   always_ff @(posedge clk) begin
      if (rst) begin
         stg1_v <= 1'b0;
         stg2_v <= 1'b0;
         stg3_v <= 1'b0;
      end else if (advance) begin
         stg1_v <= in_valid;
         stg2_v <= stg1_v;
         stg3_v <= stg2_v;
      end
   end

   p_accept_r8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> stg1_v);

   p_rise_from_stage2_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(stg3_v) |-> $past(stg2_v));

   p_stall_blocks_input_r9: assert property (@(posedge clk) disable iff (rst)
      (stg3_v && !out_ready) |-> !in_ready);
endmodule

// File: rtl/pmac52_lane.sv
module pmac52_lane
   import pmac52_pkg::*;
#(
   parameter int ACC_W = LANE_W,
   parameter int OPD_W = MUL_W
) (
   input  logic             clk,
   input  logic             en,
   input  logic             sel_hi,
   input  logic [ACC_W-1:0] acc,
   input  logic [OPD_W-1:0] mula,
   input  logic [OPD_W-1:0] mulb,
   output logic [ACC_W-1:0] sum
);
   localparam int PW = 2 * OPD_W;

   // Stage 1: operand capture
   logic [OPD_W-1:0] a_s1, b_s1;
   logic [ACC_W-1:0] acc_s1, acc_s2, sum_s3;
   half_sel_t        half_s1, half_s2;
   logic [PW-1:0]    prod_s2;
   logic [OPD_W-1:0] addend;

   always_ff @(posedge clk) begin
      if (en) begin
         a_s1    <= mula;
         b_s1    <= mulb;
         acc_s1  <= acc;
         half_s1 <= half_sel_t'(sel_hi);
      end
   end

   // Stage 2: full-width unsigned product
   always_ff @(posedge clk) begin
      if (en) begin
         prod_s2 <= {{OPD_W{1'b0}}, a_s1} * {{OPD_W{1'b0}}, b_s1};
         acc_s2  <= acc_s1;
         half_s2 <= half_s1;
      end
   end

   // Stage 3: half select and wrapping accumulate
   always_comb begin
      if (half_s2 == HALF_HI) addend = prod_s2[PW-1:OPD_W];
      else                    addend = prod_s2[OPD_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (en) sum_s3 <= acc_s2 + ACC_W'(addend);
   end

   assign sum = sum_s3;
endmodule

// File: rtl/pmac52_unit.sv
module pmac52_unit
   import pmac52_pkg::*;
#(
   parameter int LANES     = 4,
   parameter int MAX_LANES = 4,
   localparam int VEC_W    = LANE_W * MAX_LANES
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             in_hi,
   input  logic [VEC_W-1:0] in_acc,
   input  logic [VEC_W-1:0] in_mula,
   input  logic [VEC_W-1:0] in_mulb,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [VEC_W-1:0] out_data
);
   // Elaboration-time parameter checks
   if (!(LANES == 2 || LANES == 4)) begin : g_bad_lanes
      $error("pmac52_unit: LANES must be 2 or 4");
   end
   if (LANES > MAX_LANES) begin : g_bad_max
      $error("pmac52_unit: LANES exceeds MAX_LANES");
   end
   if (MUL_W >= LANE_W) begin : g_bad_mulw
      $error("pmac52_unit: multiplicand width must be below lane width");
   end

   logic advance;

   pmac52_flow u_flow (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .out_ready (out_ready),
      .in_ready  (in_ready),
      .advance   (advance),
      .out_valid (out_valid)
   );

   for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
      if (j < LANES) begin : g_act
         logic unused_top_bits;
         assign unused_top_bits = ^{in_mula[LANE_W*j+MUL_W +: LANE_W-MUL_W],
                                    in_mulb[LANE_W*j+MUL_W +: LANE_W-MUL_W]};
         pmac52_lane #(
            .ACC_W (LANE_W),
            .OPD_W (MUL_W)
         ) u_lane (
            .clk    (clk),
            .en     (advance),
            .sel_hi (in_hi),
            .acc    (in_acc [LANE_W*j +: LANE_W]),
            .mula   (in_mula[LANE_W*j +: MUL_W]),
            .mulb   (in_mulb[LANE_W*j +: MUL_W]),
            .sum    (out_data[LANE_W*j +: LANE_W])
         );
      end else begin : g_off
         logic unused_lane_bits;
         assign unused_lane_bits = ^{in_acc [LANE_W*j +: LANE_W],
                                     in_mula[LANE_W*j +: LANE_W],
                                     in_mulb[LANE_W*j +: LANE_W]};
         assign out_data[LANE_W*j +: LANE_W] = '0;
      end
   end

   p_hold_under_stall_r9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/sim_pmac52_unit.sv
module sim_pmac52_unit;
   localparam int VW = 256;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   logic          in_valid = 1'b0, in_hi = 1'b0, out_ready = 1'b0;
   logic [VW-1:0] in_acc = '0, in_mula = '0, in_mulb = '0;
   logic          in_ready0, in_ready1, out_valid0, out_valid1;
   logic [VW-1:0] out0, out1;

   pmac52_unit #(.LANES(4), .MAX_LANES(4)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready0),
      .in_hi(in_hi), .in_acc(in_acc), .in_mula(in_mula), .in_mulb(in_mulb),
      .out_valid(out_valid0), .out_ready(out_ready), .out_data(out0));

   pmac52_unit #(.LANES(2), .MAX_LANES(4)) u1 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready1),
      .in_hi(in_hi), .in_acc(in_acc), .in_mula(in_mula), .in_mulb(in_mulb),
      .out_valid(out_valid1), .out_ready(out_ready), .out_data(out1));

   int checks = 0;
   int errors = 0;
   logic [VW-1:0] exp4_q[$];
   logic [VW-1:0] exp2_q[$];
   logic          mode_q[$];
   logic          stalled_prev = 1'b0;
   logic [VW-1:0] held0 = '0, held1 = '0;

   function automatic logic [63:0] lane_ref(logic [63:0] acc, logic [63:0] a,
                                            logic [63:0] b, logic hi);
      logic [103:0] x, y, p;
      x = {52'd0, a[51:0]};
      y = {52'd0, b[51:0]};
      p = x * y;
      if (hi) return acc + {12'd0, p[103:52]};
      return acc + {12'd0, p[51:0]};
   endfunction

   function automatic logic [VW-1:0] vec_ref(int lanes, logic [VW-1:0] acc,
                                             logic [VW-1:0] a, logic [VW-1:0] b,
                                             logic hi);
      logic [VW-1:0] r;
      r = '0;
      for (int j = 0; j < 4; j++)
         if (j < lanes) r[64*j +: 64] = lane_ref(acc[64*j +: 64], a[64*j +: 64],
                                                 b[64*j +: 64], hi);
      return r;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [VW-1:0] act, input logic [VW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom, $urandom};
   endfunction

   function automatic logic [VW-1:0] rndvec();
      return {rnd64(), rnd64(), rnd64(), rnd64()};
   endfunction

   // One cycle: drive at the falling edge, then judge the coming rising edge
   task automatic step(input logic v, input logic h, input logic [VW-1:0] acc,
                       input logic [VW-1:0] a, input logic [VW-1:0] b,
                       input logic rdy);
      @(negedge clk);
      in_valid  = v;
      in_hi     = h;
      in_acc    = acc;
      in_mula   = a;
      in_mulb   = b;
      out_ready = rdy;
      #1;
      if (stalled_prev) begin
         check(out_valid0 && out0 == held0, "R9 hold 4-lane", out0, held0);
         check(out_valid1 && out1 == held1, "R9 hold 2-lane", out1, held1);
      end
      check(out_valid1 == out_valid0 && in_ready1 == in_ready0,
            "R8 instances agree on handshake", VW'(out_valid1), VW'(out_valid0));
      if (out_valid0 && out_ready) begin
         if (exp4_q.size() == 0) begin
            check(1'b0, "R9 unexpected result", out0, '0);
         end else begin
            logic [VW-1:0] e4, e2;
            logic md;
            e4 = exp4_q.pop_front();
            e2 = exp2_q.pop_front();
            md = mode_q.pop_front();
            if (md) begin
               check(out0 == e4, "R3 high half 4-lane", out0, e4);
               check(out1 == e2, "R3 R7 high half 2-lane", out1, e2);
            end else begin
               check(out0 == e4, "R4 low half 4-lane", out0, e4);
               check(out1 == e2, "R4 R7 low half 2-lane", out1, e2);
            end
         end
      end
      if (out_valid0 && !out_ready) begin
         check(!in_ready0, "R9 in_ready low under stall", VW'(in_ready0), '0);
         stalled_prev = 1'b1;
         held0 = out0;
         held1 = out1;
      end else begin
         stalled_prev = 1'b0;
      end
      if (in_valid && in_ready0) begin
         exp4_q.push_back(vec_ref(4, acc, a, b, h));
         exp2_q.push_back(vec_ref(2, acc, a, b, h));
         mode_q.push_back(h);
      end
   endtask

   task automatic drain();
      for (int k = 0; k < 8; k++) step(1'b0, 1'b0, '0, '0, '0, 1'b1);
      check(exp4_q.size() == 0, "R9 every request answered",
            VW'(exp4_q.size()), '0);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [VW-1:0] ones, m52, junk;
      void'($urandom(32'd20240611));
      ones = '1;
      m52  = {4{64'h000F_FFFF_FFFF_FFFF}};
      junk = {4{64'hABC0_0000_0000_0000}};

      // R10: reset state
      repeat (3) @(negedge clk);
      #1;
      check(!out_valid0 && !out_valid1, "R10 out_valid low in reset",
            VW'(out_valid0), '0);
      check(in_ready0 && in_ready1, "R10 in_ready high in reset",
            VW'(in_ready0), VW'(1));
      @(negedge clk);
      rst = 1'b0;

      // R8: exact latency with an empty pipeline
      step(1'b1, 1'b1, '0, m52, m52, 1'b1);
      step(1'b0, 1'b0, '0, '0, '0, 1'b1);
      check(!out_valid0, "R8 no result after 1st edge", VW'(out_valid0), '0);
      step(1'b0, 1'b0, '0, '0, '0, 1'b1);
      check(!out_valid0, "R8 no result after 2nd edge", VW'(out_valid0), '0);
      step(1'b0, 1'b0, '0, '0, '0, 1'b1);
      check(out_valid0, "R8 result after 3rd edge", VW'(out_valid0), VW'(1));
      drain();

      // R2: all-ones 52-bit operands, both halves
      step(1'b1, 1'b1, '0, m52, m52, 1'b1);
      step(1'b1, 1'b0, '0, m52, m52, 1'b1);
      drain();
      // R1: junk in bits [63:52] of the multiplicands
      step(1'b1, 1'b1, '0, m52 | junk, m52 | junk, 1'b1);
      step(1'b1, 1'b0, rndvec(), rndvec() | junk, rndvec(), 1'b1);
      // R5 R6: full accumulator, wraparound, no inter-lane carry
      step(1'b1, 1'b0, ones, m52, m52, 1'b1);
      step(1'b1, 1'b1, ones, m52, m52, 1'b1);
      step(1'b1, 1'b0, {4{64'hFFFF_0000_0000_0000}}, {4{64'd3}}, {4{64'd5}}, 1'b1);
      drain();
      check(out1[VW-1:128] == '0, "R7 upper result lanes zero", out1, '0);

      // R10: reset while the pipeline is full and stalled
      step(1'b1, 1'b1, rndvec(), rndvec(), rndvec(), 1'b0);
      step(1'b1, 1'b0, rndvec(), rndvec(), rndvec(), 1'b0);
      step(1'b1, 1'b1, rndvec(), rndvec(), rndvec(), 1'b0);
      step(1'b0, 1'b0, '0, '0, '0, 1'b0);
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);
      #1;
      check(!out_valid0 && !out_valid1, "R10 reset empties pipeline",
            VW'(out_valid0), '0);
      exp4_q.delete();
      exp2_q.delete();
      mode_q.delete();
      stalled_prev = 1'b0;
      rst = 1'b0;

      // Random traffic with backpressure
      for (int n = 0; n < 600; n++) begin
         logic v, h, r;
         logic [VW-1:0] acc, a, b;
         v = ($urandom % 4) != 0;
         h = $urandom % 2;
         r = ($urandom % 10) < 6;
         acc = rndvec();
         a = rndvec();
         b = rndvec();
         if (($urandom % 8) == 0) a = a | m52;
         if (($urandom % 8) == 0) acc = ones;
         step(v, h, acc, a, b, r);
      end
      drain();
      finish_run();
   end
endmodule